// File: doc/BRIEF.md
# Vectored Two-Line Interrupt Controller

This block gathers 32 level-sensitive peripheral interrupt requests and presents them to a processor as two active-low lines: a normal interrupt line and a fast interrupt line. Each request is qualified by an enable mask. A per-source route bit then sends each enabled request to one of the two lines. Software sees the qualified status for each line, the unqualified request levels and the configuration through a small 32-bit register port addressed by byte offset, with separate read and write strobes.

The block also keeps a vector register that the interrupt service code reads to find its handler. It holds 16 vector slots and 16 vector control slots. Two sources, a timer at bit 4 and a serial port at bit 6, load the vector register from their own slot while they are pending on the normal line. The timer wins when both are pending. The enable register and its clear companion are always kept as exact bitwise complements.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The normal status (offset 0x000) reads `raw_req & enable & ~route`. The fast status (offset 0x004) reads `raw_req & enable & route`. Offset 0x008 reads `raw_req` unqualified. A route bit of 1 sends its source to the fast line.
- R2: `irq_n` is 0 in the same cycle the normal status is nonzero and is 1 otherwise. `fiq_n` follows the fast status in the same way. Neither output waits for a clock edge.
- R3: A write to offset 0x010 sets the enable mask to the data and sets the enable-clear register (offset 0x014) to its inverse. A write to 0x014 sets the enable-clear register to the data and sets the enable mask to its inverse. Both registers read back.
- R4: Writes to offsets 0x000, 0x004 and 0x008 change no register. The enable mask, the route register and all status reads are the same afterwards.
- R5: 16 vector slots at offset 0x100 + 4k and 16 vector control slots at offset 0x200 + 4k (k = 0..15) are each written and read back independently.
- R6: On every clock edge where source 4 is in the normal status, the vector register (offset 0x030) loads slot 4. Otherwise, if source 4 is absent and source 6 is in the normal status, it loads slot 6. Either load overrides a write to 0x030 in the same cycle.
- R7: When neither source 4 nor source 6 is in the normal status, a write to 0x030 loads the vector register. Offsets 0x00C (route), 0x018, 0x01C, 0x020 and 0x034 are plain read/write storage.
- R8: A read at any offset not listed in R1–R7 (R1 to R7), including offsets whose low two bits are not zero, returns 0xFFFFFFFF. A write there changes nothing.
- R9: After reset the enable mask is 0, enable-clear is 0xFFFFFFFF, and route, the vector register and all slots are 0. Both status registers read 0, and `irq_n` and `fiq_n` are 1.
- R10: `bus_rdata` is 0 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational from the offset |
| raw_req | input | 32 | Level interrupt requests, one bit per source |
| irq_n | output | 1 | Normal interrupt line, active low |
| fiq_n | output | 1 | Fast interrupt line, active low |

## Verification
Two functions can act on the vector register at the same clock edge: the hardware load from a source slot and a software write to offset 0x030. A third case is a write to slot 4 arriving while the timer load reads that slot. The bench holds the timer request active and issues the write in the same cycle. It then reads the vector register and expects the slot value, not the written data. For the slot-write case it expects the slot value from before the write on the first edge and the new value one edge later. The bench also moves the route bit of source 4 to the fast line, which hands the vector over to source 6. Each expected value comes from the bench's own model of the ranking.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

  localparam int DW         = 32;
  localparam int NSRC       = 32;
  localparam int AW         = 12;
  localparam int NSLOT      = 16;
  localparam int SLOT_IDX_W = $clog2(NSLOT);

  localparam logic [AW-1:0] OFF_IRQST   = 12'h000;
  localparam logic [AW-1:0] OFF_FIQST   = 12'h004;
  localparam logic [AW-1:0] OFF_RAW     = 12'h008;
  localparam logic [AW-1:0] OFF_ROUTE   = 12'h00C;
  localparam logic [AW-1:0] OFF_EN      = 12'h010;
  localparam logic [AW-1:0] OFF_ENCLR   = 12'h014;
  localparam logic [AW-1:0] OFF_SOFT    = 12'h018;
  localparam logic [AW-1:0] OFF_SOFTCLR = 12'h01C;
  localparam logic [AW-1:0] OFF_GUARD   = 12'h020;
  localparam logic [AW-1:0] OFF_VEC     = 12'h030;
  localparam logic [AW-1:0] OFF_DEFVEC  = 12'h034;
  localparam logic [AW-1:0] OFF_VSLOT   = 12'h100;
  localparam logic [AW-1:0] OFF_VCTL    = 12'h200;
  localparam logic [AW-1:0] SLOT_SPAN   = AW'(4 * NSLOT);

  localparam int TIMER_SRC  = 4;
  localparam int SERIAL_SRC = 6;

  typedef enum logic [3:0] {
    K_IRQST, K_FIQST, K_RAW, K_ROUTE, K_EN, K_ENCLR, K_SOFT, K_SOFTCLR,
    K_GUARD, K_VEC, K_DEFVEC, K_VSLOT, K_VCTL, K_NONE
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e             kind;
    logic [SLOT_IDX_W-1:0] idx;
  } reg_hit_t;

  function automatic reg_hit_t decode_off(input logic [AW-1:0] off);
    reg_hit_t h;
    logic [AW-1:0] rel;
    h.kind = K_NONE;
    h.idx  = '0;
    rel    = '0;
    if (off[1:0] == 2'b00) begin
      case (off)
        OFF_IRQST:   h.kind = K_IRQST;
        OFF_FIQST:   h.kind = K_FIQST;
        OFF_RAW:     h.kind = K_RAW;
        OFF_ROUTE:   h.kind = K_ROUTE;
        OFF_EN:      h.kind = K_EN;
        OFF_ENCLR:   h.kind = K_ENCLR;
        OFF_SOFT:    h.kind = K_SOFT;
        OFF_SOFTCLR: h.kind = K_SOFTCLR;
        OFF_GUARD:   h.kind = K_GUARD;
        OFF_VEC:     h.kind = K_VEC;
        OFF_DEFVEC:  h.kind = K_DEFVEC;
        default: begin
          if (off >= OFF_VSLOT && off < OFF_VSLOT + SLOT_SPAN) begin
            rel    = off - OFF_VSLOT;
            h.kind = K_VSLOT;
            h.idx  = rel[2 +: SLOT_IDX_W];
          end else if (off >= OFF_VCTL && off < OFF_VCTL + SLOT_SPAN) begin
            rel    = off - OFF_VCTL;
            h.kind = K_VCTL;
            h.idx  = rel[2 +: SLOT_IDX_W];
          end
        end
      endcase
    end
    return h;
  endfunction

  function automatic logic [NSRC-1:0] normal_set(input logic [NSRC-1:0] raw,
                                                  input logic [NSRC-1:0] en,
                                                  input logic [NSRC-1:0] route);
    return raw & en & ~route;
  endfunction

  function automatic logic [NSRC-1:0] fast_set(input logic [NSRC-1:0] raw,
                                                input logic [NSRC-1:0] en,
                                                input logic [NSRC-1:0] route);
    return raw & en & route;
  endfunction

endpackage

// File: rtl/ivc_route.sv
module ivc_route #(
  parameter int NSRC = 32
) (
  input  logic [NSRC-1:0] raw_req,
  input  logic [NSRC-1:0] en_mask,
  input  logic [NSRC-1:0] route,
  output logic [NSRC-1:0] irq_stat,
  output logic [NSRC-1:0] fiq_stat,
  output logic            irq_n,
  output logic            fiq_n
);
  import ivc_pkg::*;

  always_comb begin
    irq_stat = normal_set(raw_req, en_mask, route);
    fiq_stat = fast_set(raw_req, en_mask, route);
    irq_n    = ~(|irq_stat);
    fiq_n    = ~(|fiq_stat);
  end

endmodule

// File: rtl/ivc_vecpick.sv
module ivc_vecpick #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_hi,
  input  logic          hit_lo,
  input  logic [DW-1:0] hi_vec,
  input  logic [DW-1:0] lo_vec,
  input  logic          sw_we,
  input  logic [DW-1:0] sw_data,
  output logic [DW-1:0] vec_q
);

  logic hw_load_hi;
  logic hw_load_lo;
  logic sw_load;

  assign hw_load_hi = hit_hi;
  assign hw_load_lo = hit_lo & ~hit_hi;
  assign sw_load    = sw_we & ~hit_hi & ~hit_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          vec_q <= '0;
    else if (hw_load_hi) vec_q <= hi_vec;
    else if (hw_load_lo) vec_q <= lo_vec;
    else if (sw_load)    vec_q <= sw_data;
  end

  AST_VEC_TIMER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hit_hi |=> vec_q == $past(hi_vec)); // R6
  AST_VEC_SERIAL: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_lo && !hit_hi) |=> vec_q == $past(lo_vec)); // R6
  AST_VEC_SW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && !hit_hi && !hit_lo) |=> vec_q == $past(sw_data)); // R7
  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we && !hit_hi && !hit_lo) |=> $stable(vec_q)); // R7

endmodule

// File: rtl/ivc_regfile.sv
module ivc_regfile #(
  parameter int DW     = 32,
  parameter int NSRC   = 32,
  parameter int AW     = 12,
  parameter int NSLOT  = 16,
  parameter int HI_SRC = 4,
  parameter int LO_SRC = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic            bus_rd,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] raw_req,
  input  logic [NSRC-1:0] irq_stat,
  input  logic [NSRC-1:0] fiq_stat,
  input  logic [DW-1:0]   vec_q,
  output logic [NSRC-1:0] en_mask,
  output logic [NSRC-1:0] route,
  output logic [DW-1:0]   hi_vec,
  output logic [DW-1:0]   lo_vec,
  output logic            vec_we
);
  import ivc_pkg::*;

  localparam int IDX_W = $clog2(NSLOT);

  reg_hit_t        hit;
  logic [NSRC-1:0] en_q, enclr_q, route_q;
  logic [DW-1:0]   soft_q, softclr_q, guard_q, defvec_q;
  logic [DW-1:0]   vslot [NSLOT];
  logic [DW-1:0]   vctl  [NSLOT];
  logic [DW-1:0]   rd_val;
  logic            wr_status;

  assign hit       = decode_off(bus_addr);
  assign wr_status = bus_wr && (hit.kind == K_IRQST || hit.kind == K_FIQST
                                || hit.kind == K_RAW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      enclr_q <= '1;
    end else if (bus_wr && hit.kind == K_EN) begin
      en_q    <= bus_wdata[NSRC-1:0];
      enclr_q <= ~bus_wdata[NSRC-1:0];
    end else if (bus_wr && hit.kind == K_ENCLR) begin
      enclr_q <= bus_wdata[NSRC-1:0];
      en_q    <= ~bus_wdata[NSRC-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q   <= '0;
      soft_q    <= '0;
      softclr_q <= '0;
      guard_q   <= '0;
      defvec_q  <= '0;
    end else if (bus_wr) begin
      case (hit.kind)
        K_ROUTE:   route_q   <= bus_wdata[NSRC-1:0];
        K_SOFT:    soft_q    <= bus_wdata;
        K_SOFTCLR: softclr_q <= bus_wdata;
        K_GUARD:   guard_q   <= bus_wdata;
        K_DEFVEC:  defvec_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    logic sel_k;
    assign sel_k = bus_wr && (hit.idx == IDX_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vslot[k] <= '0;
        vctl[k]  <= '0;
      end else if (sel_k) begin
        if (hit.kind == K_VSLOT) vslot[k] <= bus_wdata;
        if (hit.kind == K_VCTL)  vctl[k]  <= bus_wdata;
      end
    end
  end

  always_comb begin
    rd_val = '1;
    case (hit.kind)
      K_IRQST:   rd_val = DW'(irq_stat);
      K_FIQST:   rd_val = DW'(fiq_stat);
      K_RAW:     rd_val = DW'(raw_req);
      K_ROUTE:   rd_val = DW'(route_q);
      K_EN:      rd_val = DW'(en_q);
      K_ENCLR:   rd_val = DW'(enclr_q);
      K_SOFT:    rd_val = soft_q;
      K_SOFTCLR: rd_val = softclr_q;
      K_GUARD:   rd_val = guard_q;
      K_VEC:     rd_val = vec_q;
      K_DEFVEC:  rd_val = defvec_q;
      K_VSLOT:   rd_val = vslot[hit.idx];
      K_VCTL:    rd_val = vctl[hit.idx];
      default:   rd_val = '1;
    endcase
  end

  assign bus_rdata = bus_rd ? rd_val : '0;
  assign en_mask   = en_q;
  assign route     = route_q;
  assign hi_vec    = vslot[HI_SRC];
  assign lo_vec    = vslot[LO_SRC];
  assign vec_we    = bus_wr && hit.kind == K_VEC;

  AST_EN_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    en_q == ~enclr_q); // R3
  AST_RO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_status |=> $stable(en_q) && $stable(route_q) && $stable(defvec_q)); // R4
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == '0); // R10

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int DW    = ivc_pkg::DW,
  parameter int NSRC  = ivc_pkg::NSRC,
  parameter int AW    = ivc_pkg::AW,
  parameter int NSLOT = ivc_pkg::NSLOT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic            bus_rd,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] raw_req,
  output logic            irq_n,
  output logic            fiq_n
);
  import ivc_pkg::*;

  logic [NSRC-1:0] en_mask, route, irq_stat, fiq_stat;
  logic [DW-1:0]   hi_vec, lo_vec, vec_q;
  logic            vec_we;
  reg_hit_t        top_hit;

  assign top_hit = decode_off(bus_addr);

  ivc_route #(.NSRC(NSRC)) u_route (
    .raw_req (raw_req),
    .en_mask (en_mask),
    .route   (route),
    .irq_stat(irq_stat),
    .fiq_stat(fiq_stat),
    .irq_n   (irq_n),
    .fiq_n   (fiq_n)
  );

  ivc_regfile #(
    .DW(DW), .NSRC(NSRC), .AW(AW), .NSLOT(NSLOT),
    .HI_SRC(TIMER_SRC), .LO_SRC(SERIAL_SRC)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rd   (bus_rd),
    .bus_rdata(bus_rdata),
    .raw_req  (raw_req),
    .irq_stat (irq_stat),
    .fiq_stat (fiq_stat),
    .vec_q    (vec_q),
    .en_mask  (en_mask),
    .route    (route),
    .hi_vec   (hi_vec),
    .lo_vec   (lo_vec),
    .vec_we   (vec_we)
  );

  ivc_vecpick #(.DW(DW)) u_vec (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit_hi (irq_stat[TIMER_SRC]),
    .hit_lo (irq_stat[SERIAL_SRC]),
    .hi_vec (hi_vec),
    .lo_vec (lo_vec),
    .sw_we  (vec_we),
    .sw_data(bus_wdata),
    .vec_q  (vec_q)
  );

  AST_IRQ_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n == ((raw_req & en_mask & ~route) == '0)); // R2
  AST_FIQ_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_n == ((raw_req & en_mask & route) == '0)); // R2
  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && top_hit.kind == K_NONE) |-> bus_rdata == '1); // R8
  AST_NORMAL_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFF_IRQST) |-> bus_rdata == DW'(raw_req & en_mask & ~route)); // R1

endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] raw_req = '0;
  logic        irq_n, fiq_n;

  int nvec = 0;
  int nbad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .raw_req(raw_req), .irq_n(irq_n), .fiq_n(fiq_n)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  function automatic bit mapped(input int off);
    if (off % 4 != 0) return 0;
    if (off <= 'h20) return 1;
    if (off == 'h30 || off == 'h34) return 1;
    if (off >= 'h100 && off < 'h140) return 1;
    if (off >= 'h200 && off < 'h240) return 1;
    return 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [31:0] v, en, sel, raw, e_irq, e_fiq;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    #1 chk("R9 irq_n", {31'd0, irq_n}, 32'd1);
    chk("R9 fiq_n", {31'd0, fiq_n}, 32'd1);
    rd(12'h010, v); chk("R9 enable", v, 32'h0);
    rd(12'h014, v); chk("R9 enable-clear", v, 32'hFFFF_FFFF);
    rd(12'h00C, v); chk("R9 route", v, 32'h0);
    rd(12'h030, v); chk("R9 vector", v, 32'h0);
    rd(12'h000, v); chk("R9 normal status", v, 32'h0);
    rd(12'h004, v); chk("R9 fast status", v, 32'h0);
    rd(12'h104, v); chk("R9 slot", v, 32'h0);

    // R10 idle read data
    @(negedge clk); bus_addr = 12'h014; #1 chk("R10 rdata idle", bus_rdata, 32'h0);

    // R3 complement sweep
    for (int k = 0; k < 32; k++) begin
      v = 32'h1 << k;
      wr(12'h010, v ^ 32'h5A00_00A5);
      rd(12'h010, e_irq); chk("R3 enable", e_irq, v ^ 32'h5A00_00A5);
      rd(12'h014, e_irq); chk("R3 enable-clear", e_irq, ~(v ^ 32'h5A00_00A5));
      wr(12'h014, v);
      rd(12'h010, e_irq); chk("R3 enable via clear", e_irq, ~v);
    end

    // R1/R2 sweep over every source and three enable/route patterns
    for (int i = 0; i < 32; i++) begin
      for (int p = 0; p < 3; p++) begin
        en  = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? ~(32'h1 << ((i + 7) % 32)) : ~(32'h1 << i);
        sel = (32'hA5A5_3C3C << p) | (32'hA5A5_3C3C >> (32 - p));
        raw = (32'h1 << i) | ((p == 2) ? 32'h00F0_0F00 : 32'h0);
        wr(12'h010, en);
        wr(12'h00C, sel);
        @(negedge clk); raw_req = raw;
        e_irq = raw & en & ~sel;
        e_fiq = raw & en & sel;
        #1 chk("R2 irq_n", {31'd0, irq_n}, {31'd0, e_irq == 0});
        chk("R2 fiq_n", {31'd0, fiq_n}, {31'd0, e_fiq == 0});
        rd(12'h000, v); chk("R1 normal status", v, e_irq);
        rd(12'h004, v); chk("R1 fast status", v, e_fiq);
        rd(12'h008, v); chk("R1 raw status", v, raw);
      end
    end

    // R4 status registers ignore writes
    en = 32'h0F0F_00FF; sel = 32'h0000_F00F; raw = 32'h1234_5678;
    wr(12'h010, en); wr(12'h00C, sel);
    @(negedge clk); raw_req = raw;
    wr(12'h000, 32'hDEAD_BEEF); wr(12'h004, 32'hFFFF_FFFF); wr(12'h008, 32'h0);
    rd(12'h010, v); chk("R4 enable kept", v, en);
    rd(12'h00C, v); chk("R4 route kept", v, sel);
    rd(12'h000, v); chk("R4 normal status", v, raw & en & ~sel);
    rd(12'h004, v); chk("R4 fast status", v, raw & en & sel);
    rd(12'h008, v); chk("R4 raw status", v, raw);
    @(negedge clk); raw_req = '0;

    // R5 slot sweep
    for (int k = 0; k < 16; k++) begin
      wr(12'(12'h100 + 4*k), 32'h1000_0000 | (k * 32'h111));
      wr(12'(12'h200 + 4*k), ~(32'h1000_0000 | (k * 32'h111)));
    end
    for (int k = 0; k < 16; k++) begin
      rd(12'(12'h100 + 4*k), v); chk("R5 vector slot", v, 32'h1000_0000 | (k * 32'h111));
      rd(12'(12'h200 + 4*k), v); chk("R5 control slot", v, ~(32'h1000_0000 | (k * 32'h111)));
    end

    // R6 ranking and same-cycle conflicts
    wr(12'h100 + 12'd16, 32'hAAAA_0004);
    wr(12'h100 + 12'd24, 32'hBBBB_0006);
    wr(12'h010, 32'h0000_0050); wr(12'h00C, 32'h0);
    @(negedge clk); raw_req = 32'h40;
    rd(12'h030, v); chk("R6 serial loads slot 6", v, 32'hBBBB_0006);
    @(negedge clk); raw_req = 32'h50;
    rd(12'h030, v); chk("R6 timer beats serial", v, 32'hAAAA_0004);
    wr(12'h030, 32'h1234_5678);
    rd(12'h030, v); chk("R6 load beats software write", v, 32'hAAAA_0004);
    @(negedge clk);
    bus_addr = 12'h110; bus_wdata = 32'hCCCC_0004; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_addr = 12'h030; bus_rd = 1'b1;
    #1 chk("R6 old slot value on write edge", bus_rdata, 32'hAAAA_0004);
    bus_rd = 1'b0;
    rd(12'h030, v); chk("R6 new slot value next edge", v, 32'hCCCC_0004);
    wr(12'h00C, 32'h10);
    rd(12'h030, v); chk("R6 timer on fast line yields to serial", v, 32'hBBBB_0006);
    #1 chk("R2 fiq_n with timer routed fast", {31'd0, fiq_n}, 32'd0);

    // R7 software write and plain storage
    @(negedge clk); raw_req = '0;
    wr(12'h030, 32'h1234_5678);
    rd(12'h030, v); chk("R7 software vector write", v, 32'h1234_5678);
    @(negedge clk); raw_req = 32'h10;
    rd(12'h030, v); chk("R7 fast-routed timer leaves vector", v, 32'h1234_5678);
    @(negedge clk); raw_req = '0;
    wr(12'h018, 32'h0101_0101); wr(12'h01C, 32'h0202_0202);
    wr(12'h020, 32'h0303_0303); wr(12'h034, 32'h0404_0404);
    rd(12'h018, v); chk("R7 soft store", v, 32'h0101_0101);
    rd(12'h01C, v); chk("R7 soft-clear store", v, 32'h0202_0202);
    rd(12'h020, v); chk("R7 guard store", v, 32'h0303_0303);
    rd(12'h034, v); chk("R7 default vector", v, 32'h0404_0404);

    // R8 unmapped offsets
    for (int off = 0; off < 4096; off += 4) begin
      if (!mapped(off)) begin
        rd(12'(off), v); chk("R8 unmapped read", v, 32'hFFFF_FFFF);
      end
    end
    rd(12'h011, v); chk("R8 unaligned read", v, 32'hFFFF_FFFF);
    wr(12'h024, 32'h0);  wr(12'h140, 32'h0); wr(12'h102, 32'h0); wr(12'h035, 32'h0);
    rd(12'h100, v); chk("R8 slot 0 untouched", v, 32'h1000_0000);
    rd(12'h034, v); chk("R8 default vector untouched", v, 32'h0404_0404);
    rd(12'h020, v); chk("R8 guard untouched", v, 32'h0303_0303);

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule